// File: doc/BRIEF.md
# Evaluation-Window Authentication Scheduler

This controller decides when to ask an external security device to prove itself, and whether traffic may flow. From the moment reset is released it runs a long evaluation window. While that window is open, the controller runs one authentication round a short delay after reset, then stays quiet. Once the window has run out, it starts a new round at a fixed interval. Inside a round, a challenge is a one-cycle strobe. The device answers with a valid/ok pair. A bad answer, or no answer before the response timeout, triggers an immediate retry. After the attempt limit is reached with no good answer, the round is abandoned and an abort flag is raised.

The authorized flag follows the latest challenge result. The traffic enable stays high for the whole evaluation window. After the window it simply mirrors the authorized flag. Every duration is a parameter counted in clock ticks, so a short configuration behaves the same way in simulation as the long one does in silicon. The challenge contents and the check of the answer lie outside the block; one pass/fail input stands in for them.

Cycle numbering used below: cycle n is the clock period that follows the n-th rising edge after reset is released.

Top module: `auth_sched`

## Requirements
- R1: While reset is held, and in cycle 1 after its release, `chal_valid_o`, `authorized_o`, `abort_o` and `attempt_cnt_o` are 0 and `traffic_en_o` is 1.
- R2: The first challenge strobe is high in cycle START_DELAY+1, for exactly one cycle. No further round is started while the evaluation window is open.
- R3: The window expires at the EVAL_TICKS-th edge after reset release and stays expired. Only a new reset restarts it, after which the first challenge again comes in cycle START_DELAY+1.
- R4: A response with `resp_ok_i`=0, sampled at edge e while a challenge is outstanding and attempts remain, puts the next challenge strobe in cycle e.
- R5: A challenge that gets no response retries RESP_TIMEOUT+2 cycles after its own strobe, while attempts remain.
- R6: `attempt_cnt_o` reads 1 during a round's first strobe and rises by one with each retry. It never exceeds MAX_ATTEMPTS. When the MAX_ATTEMPTS-th attempt fails, the round ends and `abort_o` is set. `abort_o` is cleared when the next round starts.
- R7: After expiry, a round that ends at edge e is followed by a new round whose first strobe comes in cycle e+PERIOD_TICKS+1. If the controller was idle when the window expired, the first strobe comes in cycle EVAL_TICKS+PERIOD_TICKS+2.
- R8: A good response sets `authorized_o` from the next cycle. A bad or missing response clears it. It otherwise holds its value.
- R9: `traffic_en_o` is 1 while the window is open. After expiry it equals `authorized_o`.
- R10: A response that arrives while no challenge is outstanding leaves `authorized_o`, `abort_o` and `attempt_cnt_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; restarts the evaluation window |
| resp_valid_i | input | 1 | Device answer present this cycle |
| resp_ok_i | input | 1 | Answer judged correct (meaningful with resp_valid_i) |
| chal_valid_o | output | 1 | One-cycle challenge strobe |
| authorized_o | output | 1 | Result of the latest challenge |
| traffic_en_o | output | 1 | Traffic gate |
| abort_o | output | 1 | Last round used all attempts without success |
| attempt_cnt_o | output | $clog2(MAX_ATTEMPTS+1) | Attempts made in the current round |

## Verification
The bench builds the controller with START_DELAY=3, RESP_TIMEOUT=6, PERIOD_TICKS=20, EVAL_TICKS=200 and MAX_ATTEMPTS=4. With these values the single in-window round, the expiry edge and several periodic rounds all fit in 330 cycles. It sweeps four responder behaviours: always good, always bad, silent, and bad only on the first attempt of a round. For each behaviour it derives every expected strobe cycle arithmetically and compares the full list. A stray response while idle checks that responses without an outstanding challenge change nothing.

// File: rtl/auth_sched_pkg.sv
package auth_sched_pkg;

  typedef enum logic [2:0] {
    PH_STARTUP = 3'd0,
    PH_ISSUE   = 3'd1,
    PH_AWAIT   = 3'd2,
    PH_IDLE    = 3'd3,
    PH_PERIOD  = 3'd4
  } phase_e;

  // Largest of three durations, used to size the shared tick timer.
  function automatic longint unsigned max3(input longint unsigned a,
                                           input longint unsigned b,
                                           input longint unsigned c);
    longint unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Attempt number that goes with a challenge about to be issued.
  function automatic int unsigned next_attempt(input int unsigned cur,
                                               input bit fresh_round);
    return fresh_round ? 1 : cur + 1;
  endfunction

  // A failed attempt ends the round once the limit has been used.
  function automatic bit attempts_left(input int unsigned cur,
                                       input int unsigned limit);
    return cur < limit;
  endfunction

  // Gate: open window lets traffic through, afterwards authorization rules.
  function automatic bit gate_open(input bit expired, input bit authorized);
    return !expired || authorized;
  endfunction

endpackage

// File: rtl/auth_eval_window.sv
module auth_eval_window #(
  parameter longint unsigned EVAL_TICKS = 64'd720_000_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic expired_o
);
  localparam int CW = $clog2(EVAL_TICKS + 1);

  logic [CW-1:0] elapsed_q;
  logic          expired_q;
  logic          last_tick;

  assign last_tick = (elapsed_q == CW'(EVAL_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed_q <= '0;
      expired_q <= 1'b0;
    end else if (!expired_q) begin
      elapsed_q <= elapsed_q + 1'b1;
      if (last_tick) expired_q <= 1'b1;
    end
  end

  assign expired_o = expired_q;
endmodule

// File: rtl/auth_tick_timer.sv
module auth_tick_timer #(
  parameter int              TW        = 8,
  parameter longint unsigned RESET_VAL = 64'd0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          done_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= TW'(RESET_VAL);
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/auth_round_fsm.sv
module auth_round_fsm
  import auth_sched_pkg::*;
#(
  parameter int              TW           = 8,
  parameter int              AW           = 3,
  parameter int unsigned     MAX_ATTEMPTS = 4,
  parameter longint unsigned RESP_TIMEOUT = 64'd10,
  parameter longint unsigned PERIOD_TICKS = 64'd100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          expired_i,
  input  logic          tmr_done_i,
  input  logic          resp_valid_i,
  input  logic          resp_ok_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          chal_o,
  output logic          authorized_o,
  output logic          abort_o,
  output logic [AW-1:0] attempt_o,
  output logic          good_evt_o,
  output logic          fail_evt_o
);
  phase_e        phase_q, phase_d;
  logic          auth_q, abort_q;
  logic [AW-1:0] att_q;
  logic          issue_next, fresh_round, round_end;
  logic          bad_evt, timeout_evt, can_retry;

  assign good_evt_o  = (phase_q == PH_AWAIT) && resp_valid_i && resp_ok_i;
  assign bad_evt     = (phase_q == PH_AWAIT) && resp_valid_i && !resp_ok_i;
  assign timeout_evt = (phase_q == PH_AWAIT) && !resp_valid_i && tmr_done_i;
  assign fail_evt_o  = bad_evt || timeout_evt;
  assign can_retry   = attempts_left(int'(att_q), MAX_ATTEMPTS);

  always_comb begin
    phase_d     = phase_q;
    tmr_load_o  = 1'b0;
    tmr_val_o   = '0;
    issue_next  = 1'b0;
    fresh_round = 1'b0;
    round_end   = 1'b0;
    unique case (phase_q)
      PH_STARTUP: begin
        if (tmr_done_i) begin
          phase_d     = PH_ISSUE;
          issue_next  = 1'b1;
          fresh_round = 1'b1;
        end
      end
      PH_ISSUE: begin
        phase_d    = PH_AWAIT;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(RESP_TIMEOUT);
      end
      PH_AWAIT: begin
        if (good_evt_o) begin
          round_end = 1'b1;
        end else if (fail_evt_o) begin
          if (can_retry) begin
            phase_d    = PH_ISSUE;
            issue_next = 1'b1;
          end else begin
            round_end = 1'b1;
          end
        end
        if (round_end) begin
          if (expired_i) begin
            phase_d    = PH_PERIOD;
            tmr_load_o = 1'b1;
            tmr_val_o  = TW'(PERIOD_TICKS);
          end else begin
            phase_d = PH_IDLE;
          end
        end
      end
      PH_IDLE: begin
        if (expired_i) begin
          phase_d    = PH_PERIOD;
          tmr_load_o = 1'b1;
          tmr_val_o  = TW'(PERIOD_TICKS);
        end
      end
      PH_PERIOD: begin
        if (tmr_done_i) begin
          phase_d     = PH_ISSUE;
          issue_next  = 1'b1;
          fresh_round = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_STARTUP;
      auth_q  <= 1'b0;
      abort_q <= 1'b0;
      att_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (issue_next)  att_q <= AW'(next_attempt(int'(att_q), fresh_round));
      if (fresh_round) abort_q <= 1'b0;
      else if (fail_evt_o && !can_retry) abort_q <= 1'b1;
      if (good_evt_o)      auth_q <= 1'b1;
      else if (fail_evt_o) auth_q <= 1'b0;
    end
  end

  assign chal_o       = (phase_q == PH_ISSUE);
  assign authorized_o = auth_q;
  assign abort_o      = abort_q;
  assign attempt_o    = att_q;
endmodule

// File: rtl/auth_sched.sv
module auth_sched
  import auth_sched_pkg::*;
#(
  parameter longint unsigned EVAL_TICKS   = 64'd720_000_000_000,
  parameter longint unsigned PERIOD_TICKS = 64'd6_000_000_000,
  parameter longint unsigned RESP_TIMEOUT = 64'd10_000_000,
  parameter longint unsigned START_DELAY  = 64'd1_000,
  parameter int unsigned     MAX_ATTEMPTS = 4,
  localparam int             AW           = $clog2(MAX_ATTEMPTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          resp_valid_i,
  input  logic          resp_ok_i,
  output logic          chal_valid_o,
  output logic          authorized_o,
  output logic          traffic_en_o,
  output logic          abort_o,
  output logic [AW-1:0] attempt_cnt_o
);
  localparam longint unsigned TMAX = max3(START_DELAY, RESP_TIMEOUT, PERIOD_TICKS);
  localparam int              TW   = (TMAX < 2) ? 1 : $clog2(TMAX + 1);

  logic          win_expired;
  logic          tmr_done, tmr_load;
  logic [TW-1:0] tmr_val;
  logic          good_evt, fail_evt;

  auth_eval_window #(.EVAL_TICKS(EVAL_TICKS)) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .expired_o (win_expired)
  );

  auth_tick_timer #(.TW(TW), .RESET_VAL(START_DELAY)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  auth_round_fsm #(
    .TW           (TW),
    .AW           (AW),
    .MAX_ATTEMPTS (MAX_ATTEMPTS),
    .RESP_TIMEOUT (RESP_TIMEOUT),
    .PERIOD_TICKS (PERIOD_TICKS)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .expired_i    (win_expired),
    .tmr_done_i   (tmr_done),
    .resp_valid_i (resp_valid_i),
    .resp_ok_i    (resp_ok_i),
    .tmr_load_o   (tmr_load),
    .tmr_val_o    (tmr_val),
    .chal_o       (chal_valid_o),
    .authorized_o (authorized_o),
    .abort_o      (abort_o),
    .attempt_o    (attempt_cnt_o),
    .good_evt_o   (good_evt),
    .fail_evt_o   (fail_evt)
  );

  assign traffic_en_o = gate_open(win_expired, authorized_o);
endmodule

// File: rtl/auth_sched_chk.sv
module auth_sched_chk #(
  parameter int unsigned MAX_ATTEMPTS = 4,
  parameter int          AW           = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chal,
  input logic          expired,
  input logic          authorized,
  input logic          traffic_en,
  input logic          abort,
  input logic [AW-1:0] attempt,
  input logic          good_evt,
  input logic          fail_evt
);
  logic [1:0] rounds_in_window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rounds_in_window <= '0;
    else if (chal && attempt == AW'(1) && !expired && rounds_in_window != 2'd3)
      rounds_in_window <= rounds_in_window + 1'b1;
  end

  AST_CHAL_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) chal |=> !chal); // R2
  AST_ONE_ROUND_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) rounds_in_window <= 2'd1); // R2
  AST_WINDOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n) expired |=> expired); // R3
  AST_RETRY_NEXT: assert property (@(posedge clk) disable iff (!rst_n) (fail_evt && attempt < AW'(MAX_ATTEMPTS)) |=> chal); // R4
  AST_ATTEMPT_CAP: assert property (@(posedge clk) disable iff (!rst_n) attempt <= AW'(MAX_ATTEMPTS)); // R6
  AST_ABORT_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n) abort |-> attempt == AW'(MAX_ATTEMPTS)); // R6
  AST_GOOD_SETS_AUTH: assert property (@(posedge clk) disable iff (!rst_n) good_evt |=> authorized); // R8
  AST_FAIL_CLEARS_AUTH: assert property (@(posedge clk) disable iff (!rst_n) fail_evt |=> !authorized); // R8
  AST_OPEN_WINDOW_ENABLES: assert property (@(posedge clk) disable iff (!rst_n) !expired |-> traffic_en); // R9
  AST_EXPIRED_GATE: assert property (@(posedge clk) disable iff (!rst_n) expired |-> (traffic_en == authorized)); // R9
  AST_NO_EVT_WITHOUT_CHAL: assert property (@(posedge clk) disable iff (!rst_n) (good_evt || fail_evt) |-> attempt != '0); // R10
endmodule

bind auth_sched auth_sched_chk #(.MAX_ATTEMPTS(MAX_ATTEMPTS), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chal       (chal_valid_o),
  .expired    (win_expired),
  .authorized (authorized_o),
  .traffic_en (traffic_en_o),
  .abort      (abort_o),
  .attempt    (attempt_cnt_o),
  .good_evt   (good_evt),
  .fail_evt   (fail_evt)
);

// File: tb/auth_sched_tb.sv
module auth_sched_tb;
  localparam int D = 3, T = 6, P = 20, E = 200, M = 4, LIMIT = 330;
  localparam int AW = $clog2(M + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic resp_valid_i = 1'b0;
  logic resp_ok_i = 1'b0;
  logic chal_valid_o, authorized_o, traffic_en_o, abort_o;
  logic [AW-1:0] attempt_cnt_o;

  always #5 clk = ~clk;

  auth_sched #(
    .EVAL_TICKS(64'(E)), .PERIOD_TICKS(64'(P)), .RESP_TIMEOUT(64'(T)),
    .START_DELAY(64'(D)), .MAX_ATTEMPTS(M)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .resp_valid_i(resp_valid_i), .resp_ok_i(resp_ok_i),
    .chal_valid_o(chal_valid_o), .authorized_o(authorized_o), .traffic_en_o(traffic_en_o),
    .abort_o(abort_o), .attempt_cnt_o(attempt_cnt_o)
  );

  int checks = 0, failures = 0;
  int exp_t[64], exp_idx[64], obs_t[64];
  string exp_tag[64];
  int n_exp, n_obs, first_end;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // mode 0: always good, 1: always bad, 2: silent, 3: bad on first attempt only
  task automatic gen_expected(input int mode);
    int n, gap, tail, start, k, fin;
    bit first;
    case (mode)
      0: begin n = 1; gap = 3; tail = 3; end
      1: begin n = M; gap = 3; tail = 3; end
      2: begin n = M; gap = T + 2; tail = T + 2; end
      default: begin n = 2; gap = 3; tail = 3; end
    endcase
    start = D + 1; k = 0; first = 1'b1;
    while (start <= LIMIT && k < 60) begin
      for (int i = 0; i < n; i++) begin
        if (start + i * gap <= LIMIT) begin
          exp_t[k] = start + i * gap;
          exp_idx[k] = i + 1;
          exp_tag[k] = (i != 0) ? ((mode == 2) ? "R5" : "R4") : (first ? "R2" : "R7");
          k++;
        end
      end
      fin = start + (n - 1) * gap + tail;
      if (first) first_end = fin;
      start = (fin > E) ? fin + P + 1 : E + P + 2;
      first = 1'b0;
    end
    n_exp = k;
  endtask

  task automatic run_mode(input int mode);
    int pend;
    bit exp_auth;
    exp_auth = (mode == 0) || (mode == 3);
    rst_n = 1'b0; resp_valid_i = 1'b0; resp_ok_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(chal_valid_o == 1'b0, "R1 chal in reset", chal_valid_o, 0);
    check(authorized_o == 1'b0, "R1 authorized in reset", authorized_o, 0);
    check(abort_o == 1'b0, "R1 abort in reset", abort_o, 0);
    check(attempt_cnt_o == '0, "R1 attempts in reset", attempt_cnt_o, 0);
    check(traffic_en_o == 1'b1, "R1 traffic_en in reset", traffic_en_o, 1);
    rst_n = 1'b1;
    gen_expected(mode);
    pend = 0; n_obs = 0;
    for (int n = 1; n <= LIMIT; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (n == 1) begin
        check(chal_valid_o == 1'b0 && attempt_cnt_o == '0, "R1 idle after release", attempt_cnt_o, 0);
        check(traffic_en_o == 1'b1, "R1 enable after release", traffic_en_o, 1);
      end
      if (n == E - 1) check(traffic_en_o == 1'b1, "R3 R9 window still open", traffic_en_o, 1);
      if (n == E) check(traffic_en_o == exp_auth, "R9 gate after expiry", traffic_en_o, exp_auth);
      if (n == first_end) begin
        check(authorized_o == exp_auth, "R8 authorized after first round", authorized_o, exp_auth);
        check(abort_o == !exp_auth, "R6 abort after first round", abort_o, !exp_auth);
        check(int'(attempt_cnt_o) == ((mode == 0) ? 1 : (mode == 3) ? 2 : M),
              "R6 attempts after first round", attempt_cnt_o, (mode == 0) ? 1 : (mode == 3) ? 2 : M);
      end
      if (n == 103) begin
        check(authorized_o == exp_auth, "R10 stray response ignored (auth)", authorized_o, exp_auth);
        check(abort_o == !exp_auth, "R10 stray response ignored (abort)", abort_o, !exp_auth);
      end
      if (chal_valid_o) begin
        if (n_obs < 64) obs_t[n_obs] = n;
        if (n_obs < n_exp)
          check(int'(attempt_cnt_o) == exp_idx[n_obs], "R6 attempt count at strobe", attempt_cnt_o, exp_idx[n_obs]);
        n_obs++;
      end
      resp_valid_i = 1'b0; resp_ok_i = 1'b0;
      if (n == 100) begin
        resp_valid_i = 1'b1; resp_ok_i = !exp_auth;
      end
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          resp_valid_i = 1'b1;
          resp_ok_i = (mode == 0) || (mode == 3 && obs_t[n_obs - 1] != 0 && int'(attempt_cnt_o) != 1);
        end
      end
      if (chal_valid_o && mode != 2) pend = 2;
    end
    check(n_obs == n_exp, "R7 strobe count", n_obs, n_exp);
    for (int i = 0; i < n_exp && i < n_obs; i++)
      check(obs_t[i] == exp_t[i], exp_tag[i], obs_t[i], exp_t[i]);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int mode = 0; mode < 4; mode++) run_mode(mode);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule